// File: doc/BRIEF.md
# Control-Store Loader Register Slave

This block sits on a processor's internal-register access port and holds the three registers used to load a writable control store: a loader address register, a loader data register and a microbreak address register. The processor names a register with a 6-bit number, asserts a read or write strobe, and passes 32-bit data. Each write to the data register hands a 32-bit word to the store. It also advances a 2-bit sub-word counter kept inside the address register. The 13-bit word address moves forward only when that counter reaches its top value, so a run of data writes fills consecutive store words without software reloading the address.

The register values drive the store loader and the microbreak comparator directly through dedicated outputs. The store RAM, the comparator and microcode execution live outside this block. An access to a number the block does not decode produces a reserved-operand fault pulse back to the processor.

Top module: `csl_regif`

## Requirements
- R1: Register number 0x2C is the loader address register. A write stores bits 15:0 of the write data, and a read returns those 16 bits zero-extended to 32 bits.
- R2: A write to register number 0x2D stores all 32 write-data bits on `cs_wdata`. The same write adds one, modulo 4, to the counter field in address bits 14:13 and leaves bit 15 unchanged.
- R3: When a data write leaves the counter field equal to 3, the word address in bits 12:0 also increases by one and wraps from 0x1FFF to 0. In every other case the word address is unchanged.
- R4: A read of register number 0x2D returns 0x000000FF, whatever data was last written.
- R5: Register number 0x3C is the microbreak register. A write keeps only write-data bits 12:0, and a read returns them with bits 31:13 zero.
- R6: While reset is asserted, the address, data, microbreak and read-data registers are all zero.
- R7: `rd_fault` is high during the strobe cycle exactly when a read or write strobe names a number other than 0x2C, 0x2D or 0x3C. It is low at all other times.
- R8: A faulting write changes no register, and a faulting read returns zero read data.
- R9: Read data appears on `rd_data` in the cycle after the read strobe and holds until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_num | input | 6 | Register number of the access |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_fault | output | 1 | Reserved-operand fault, same cycle as the strobe |
| cs_ctl_addr | output | 16 | Loader address register (counter and word address) |
| cs_wdata | output | 32 | Last word written to the data register |
| brk_addr | output | 13 | Microbreak address |

## Verification
The hardest cases to reach are the two boundary events: the word address wrapping at 13 bits, and the address step landing on the third counter value when bit 15 is set. A run of data writes from reset would need tens of thousands of cycles to get there. The stimulus instead loads the address register directly with values just below these boundaries, for example 0x5FFF and 0xDFFE. It then issues runs of data writes and compares every intermediate address against an arithmetic model. A sweep of all 64 register numbers then probes the fault decode, and checks after each faulting write that no output register moved.

// File: rtl/csl_pkg.sv
package csl_pkg;
  typedef struct packed {
    logic addr;
    logic data;
    logic brk;
  } csl_sel_t;
endpackage

// File: rtl/csl_decode.sv
module csl_decode
  import csl_pkg::*;
#(
  parameter int              RNUM_W  = 6,
  parameter logic [RNUM_W-1:0] RN_ADDR = 6'h2C,
  parameter logic [RNUM_W-1:0] RN_DATA = 6'h2D,
  parameter logic [RNUM_W-1:0] RN_BRK  = 6'h3C
) (
  input  logic [RNUM_W-1:0] reg_num,
  input  logic              rd_stb,
  input  logic              wr_stb,
  output csl_sel_t          sel,
  output logic              fault
);
  always_comb begin
    sel.addr = (reg_num == RN_ADDR);
    sel.data = (reg_num == RN_DATA);
    sel.brk  = (reg_num == RN_BRK);
    fault    = (rd_stb || wr_stb) && !(sel.addr || sel.data || sel.brk);
  end

  // A register number selects at most one register (R7)
  always_comb begin
    assert_sel_onehot_R7: assert ($onehot0({sel.addr, sel.data, sel.brk}));
  end
endmodule

// File: rtl/csl_addr_reg.sv
module csl_addr_reg #(
  parameter int AREG_W  = 16,
  parameter int WADDR_W = 13,
  parameter int CTR_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [AREG_W-1:0] ld_val,
  input  logic              step_en,
  output logic [AREG_W-1:0] q
);
  localparam logic [CTR_W-1:0] CTR_MAX = '1;

  logic [CTR_W-1:0]   ctr_cur, ctr_nxt;
  logic [WADDR_W-1:0] word_cur, word_nxt;
  logic [AREG_W-1:0]  step_val, d;
  logic               en;

  always_comb begin
    ctr_cur  = q[WADDR_W +: CTR_W];
    word_cur = q[WADDR_W-1:0];
    ctr_nxt  = ctr_cur + 1'b1;
    word_nxt = (ctr_nxt == CTR_MAX) ? word_cur + 1'b1 : word_cur;
    step_val = q;
    step_val[WADDR_W +: CTR_W] = ctr_nxt;
    step_val[WADDR_W-1:0]      = word_nxt;
    en = ld_en || step_en;
    d  = ld_en ? ld_val : step_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

  assert_ctr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !ld_en) |=> (ctr_cur == CTR_W'($past(ctr_cur) + 1'b1)));

  assert_word_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !ld_en && (ctr_cur == CTR_MAX - 1'b1))
      |=> (word_cur == WADDR_W'($past(word_cur) + 1'b1)));

  assert_word_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !ld_en && (ctr_cur != CTR_MAX - 1'b1)) |=> $stable(word_cur));

  generate
    if (AREG_W > WADDR_W + CTR_W) begin : g_top_bits
      assert_top_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !ld_en) |=> $stable(q[AREG_W-1:WADDR_W+CTR_W]));
    end
  endgenerate
endmodule

// File: rtl/csl_regif.sv
module csl_regif
  import csl_pkg::*;
#(
  parameter int                RNUM_W   = 6,
  parameter int                DATA_W   = 32,
  parameter int                AREG_W   = 16,
  parameter int                WADDR_W  = 13,
  parameter int                CTR_W    = 2,
  parameter int                BRK_W    = 13,
  parameter logic [RNUM_W-1:0] RN_ADDR  = 6'h2C,
  parameter logic [RNUM_W-1:0] RN_DATA  = 6'h2D,
  parameter logic [RNUM_W-1:0] RN_BRK   = 6'h3C,
  parameter logic [DATA_W-1:0] DATA_RD_CONST = 32'h0000_00FF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RNUM_W-1:0]  reg_num,
  input  logic               rd_stb,
  input  logic               wr_stb,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_fault,
  output logic [AREG_W-1:0]  cs_ctl_addr,
  output logic [DATA_W-1:0]  cs_wdata,
  output logic [BRK_W-1:0]   brk_addr
);
  localparam int RST_STAGES = 2;

  // Reset: asserted asynchronously, released on the clock
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_q = rst_pipe[RST_STAGES-1];

  csl_sel_t sel;
  logic     fault;

  csl_decode #(
    .RNUM_W (RNUM_W),
    .RN_ADDR(RN_ADDR),
    .RN_DATA(RN_DATA),
    .RN_BRK (RN_BRK)
  ) decode_i (
    .reg_num(reg_num),
    .rd_stb (rd_stb),
    .wr_stb (wr_stb),
    .sel    (sel),
    .fault  (fault)
  );

  logic wr_addr, wr_dat, wr_brk;
  always_comb begin
    wr_addr = wr_stb && sel.addr;
    wr_dat  = wr_stb && sel.data;
    wr_brk  = wr_stb && sel.brk;
  end

  logic [AREG_W-1:0] addr_q;

  csl_addr_reg #(
    .AREG_W (AREG_W),
    .WADDR_W(WADDR_W),
    .CTR_W  (CTR_W)
  ) addr_i (
    .clk    (clk),
    .rst_n  (rst_q),
    .ld_en  (wr_addr),
    .ld_val (wr_data[AREG_W-1:0]),
    .step_en(wr_dat),
    .q      (addr_q)
  );

  // Data and microbreak registers
  logic [DATA_W-1:0] data_q, data_d;
  logic [BRK_W-1:0]  brk_q, brk_d;

  always_comb begin
    data_d = wr_data;
    brk_d  = wr_data[BRK_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      data_q <= '0;
    else if (wr_dat) data_q <= data_d;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      brk_q <= '0;
    else if (wr_brk) brk_q <= brk_d;
  end

  // Read path: registered, loaded on every read strobe
  logic [DATA_W-1:0] rd_d, rd_q;

  always_comb begin
    rd_d = '0;
    if (sel.addr)      rd_d = DATA_W'(addr_q);
    else if (sel.data) rd_d = DATA_RD_CONST;
    else if (sel.brk)  rd_d = DATA_W'(brk_q);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      rd_q <= '0;
    else if (rd_stb) rd_q <= rd_d;
  end

  assign rd_data     = rd_q;
  assign rd_fault    = fault;
  assign cs_ctl_addr = addr_q;
  assign cs_wdata    = data_q;
  assign brk_addr    = brk_q;

  assert_fault_needs_strobe_R7: assert property (@(posedge clk) disable iff (!rst_q)
    rd_fault |-> (rd_stb || wr_stb));

  assert_fault_write_hold_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_stb && rd_fault) |=> ($stable(addr_q) && $stable(data_q) && $stable(brk_q)));

  assert_data_read_const_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_stb && sel.data) |=> (rd_data == DATA_RD_CONST));

  assert_brk_read_mask_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_stb && sel.brk) |=> (rd_data[DATA_W-1:BRK_W] == '0));

  assert_fault_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_stb && rd_fault) |=> (rd_data == '0));

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_q)
    !rd_stb |=> $stable(rd_data));
endmodule

// File: tb/csl_regif_tb.sv
module csl_regif_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  reg_num;
  logic        rd_stb, wr_stb;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        rd_fault;
  logic [15:0] cs_ctl_addr;
  logic [31:0] cs_wdata;
  logic [12:0] brk_addr;

  always #5 clk = ~clk;

  csl_regif dut_i (
    .clk(clk), .rst_n(rst_n), .reg_num(reg_num), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data),
    .rd_fault(rd_fault), .cs_ctl_addr(cs_ctl_addr),
    .cs_wdata(cs_wdata), .brk_addr(brk_addr)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic do_wr(input logic [5:0] rn, input logic [31:0] v, output logic flt);
    @(negedge clk);
    reg_num = rn; wr_data = v; wr_stb = 1'b1;
    #1 flt = rd_fault;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic do_rd(input logic [5:0] rn, output logic [31:0] v, output logic flt);
    @(negedge clk);
    reg_num = rn; rd_stb = 1'b1;
    #1 flt = rd_fault;
    @(negedge clk);
    rd_stb = 1'b0;
    v = rd_data;
  endtask

  function automatic logic [15:0] step_model(input logic [15:0] a);
    logic [1:0]  c;
    logic [12:0] w;
    c = a[14:13] + 2'd1;
    w = a[12:0];
    if (c == 2'd3) w = w + 13'd1;
    return {a[15], c, w};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic        flt;
    logic [31:0] v;
    logic [15:0] model;
    logic [15:0] starts [5];
    logic [15:0] snap_a;
    logic [31:0] snap_d;
    logic [12:0] snap_b;

    starts[0] = 16'h0000; starts[1] = 16'h5FFF; starts[2] = 16'hDFFE;
    starts[3] = 16'h1234; starts[4] = 16'h7FFF;
    rst_n = 1'b0; rd_stb = 1'b0; wr_stb = 1'b0; reg_num = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R6 addr", 32'(cs_ctl_addr), 32'h0);
    chk("R6 data", cs_wdata, 32'h0);
    chk("R6 brk", 32'(brk_addr), 32'h0);
    chk("R6 rd_data", rd_data, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: address register write and read
    do_wr(6'h2C, 32'hFFFF_ABCD, flt);
    chk("R1 fault", 32'(flt), 32'h0);
    chk("R1 addr out", 32'(cs_ctl_addr), 32'h0000_ABCD);
    do_rd(6'h2C, v, flt);
    chk("R1 read", v, 32'h0000_ABCD);
    // R9: held after another access without a read
    do_wr(6'h3C, 32'h0, flt);
    chk("R9 hold", rd_data, 32'h0000_ABCD);

    // R2/R3: data write runs from several start addresses
    foreach (starts[s]) begin
      do_wr(6'h2C, {16'h0, starts[s]}, flt);
      model = starts[s];
      for (int k = 0; k < 10; k++) begin
        logic [31:0] dv;
        dv = (32'(k) * 32'h0101_0101) ^ {starts[s], starts[s]};
        do_wr(6'h2D, dv, flt);
        model = step_model(model);
        chk("R2 fault", 32'(flt), 32'h0);
        chk("R2 data", cs_wdata, dv);
        chk("R3 addr", 32'(cs_ctl_addr), 32'(model));
      end
    end

    // R4: data read constant
    do_wr(6'h2D, 32'h1234_5678, flt);
    do_rd(6'h2D, v, flt);
    chk("R4 read", v, 32'h0000_00FF);
    chk("R4 fault", 32'(flt), 32'h0);

    // R5: microbreak masking
    do_wr(6'h3C, 32'hFFFF_FFFF, flt);
    chk("R5 out", 32'(brk_addr), 32'h1FFF);
    do_rd(6'h3C, v, flt);
    chk("R5 read", v, 32'h0000_1FFF);
    do_wr(6'h3C, 32'h0002_A5A5, flt);
    do_rd(6'h3C, v, flt);
    chk("R5 read2", v, 32'h0002_A5A5 & 32'h1FFF);

    // R7/R8: sweep all register numbers
    for (int rn = 0; rn < 64; rn++) begin
      bit dec;
      dec = (rn == 'h2C) || (rn == 'h2D) || (rn == 'h3C);
      do_rd(6'(rn), v, flt);
      chk("R7 read fault", 32'(flt), 32'(!dec));
      if (!dec) begin
        chk("R8 read zero", v, 32'h0);
        snap_a = cs_ctl_addr; snap_d = cs_wdata; snap_b = brk_addr;
        do_wr(6'(rn), 32'hFFFF_FFFF, flt);
        chk("R7 write fault", 32'(flt), 32'h1);
        chk("R8 addr hold", 32'(cs_ctl_addr), 32'(snap_a));
        chk("R8 data hold", cs_wdata, snap_d);
        chk("R8 brk hold", 32'(brk_addr), 32'(snap_b));
      end
    end
    @(negedge clk);
    chk("R7 idle fault", 32'(rd_fault), 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule